// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind the serial-memory protocol engine and gathers the data bytes of one write command into a 16-entry page buffer. The engine opens a sequence with a start address, hands over each received byte with a strobe, and closes the sequence with a stop strobe. An abort strobe stands for a repeated start or a broken transfer. Nothing reaches the storage array while bytes are arriving. Only the stop decides whether the collected bytes are committed.

On a committed stop the block writes the loaded byte slots into a synchronous RAM, one slot per cycle. It holds `busy` high for a fixed, parameterised number of cycles that stands for the programming time. The protocol engine uses `busy` to withhold acknowledges. Writes wrap inside the addressed 16-byte page: the low four address bits count, and the upper bits stay fixed. A high write-protect level at the stop drops the whole buffer.

Top module: `pgwr_commit`

## Requirements
- R1: After reset `busy` and `ram_we` are low, and the buffer holds no loaded slot.
- R2: The byte loaded k places after an open at address A is written to address {A[10:4], (A[3:0]+k) mod 16}. Bits 10:4 of every write address in one commit equal A[10:4].
- R3: When more than 16 bytes arrive before the stop, the offset wraps to the start of the page. A slot that is loaded more than once is written with its most recent byte.
- R4: No RAM write occurs while bytes are being collected. `ram_we` is only ever high while `busy` is high.
- R5: A commit writes exactly the slots loaded since the open, at most 16 writes. All other addresses keep their contents.
- R6: An abort strobe, or a new open, that comes before the stop discards the loaded bytes. A stop that follows an abort starts nothing.
- R7: Write-protect is sampled in the stop cycle. If it is high, no write happens and `busy` stays low. A later sequence writes only its own bytes.
- R8: `busy` rises in the cycle after the stop strobe and stays high for exactly WRITE_CYCLES cycles. WRITE_CYCLES is raised to 16 when it is set lower. All RAM writes fall within the first 16 of those cycles.
- R9: Open, byte and stop strobes are ignored while `busy` is high. They cause no write and do not extend or restart the busy period.
- R10: A stop with no byte loaded since the open starts no write cycle.
- R11: Strobe priority in one cycle is abort, then open, then stop, then byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_begin | input | 1 | Opens a write sequence at `wr_addr` |
| wr_addr | input | ADDR_W | Start address of the sequence |
| byte_vld | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| stop_evt | input | 1 | Stop condition seen on the bus |
| abort_evt | input | 1 | Repeated start or aborted transfer |
| wp_in | input | 1 | Write protect, high blocks the commit |
| ram_we | output | 1 | RAM byte write enable |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| busy | output | 1 | Timed write cycle in progress |

## Verification
A wrong byte pointer or a corrupted page register shows up when the write pass runs. Writes land at the wrong address within at most 16 cycles after the stop, and a full-memory compare catches them. A stale valid mask appears as extra writes, or as writes missing, in the write count of the next commit. A faulty timer changes the busy length, which is measured to the exact cycle. The sweep covers every start offset with lengths from 1 to 20 bytes, so every wrap point is hit.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int unsigned PG_ADDR_W   = 11;
  localparam int unsigned PG_DATA_W   = 8;
  localparam int unsigned PG_OFS_W    = 4;
  localparam int unsigned PG_WR_TICKS = 40;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_DROP  = 2'd1,
    EV_GO    = 2'd2
  } stop_verdict_e;
endpackage

// File: rtl/pgwr_fill.sv
module pgwr_fill #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFS_W  = 4,
  localparam int unsigned SLOTS = 1 << OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [OFS_W-1:0]  open_ofs_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              clear_i,
  input  logic [OFS_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              any_o
);
  function automatic logic [OFS_W-1:0] ofs_step(input logic [OFS_W-1:0] o);
    return o + 1'b1;
  endfunction

  logic [OFS_W-1:0]  ptr_q;
  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0]  mask_q;
  logic [SLOTS-1:0]  hit_sel;

  for (genvar g = 0; g < SLOTS; g++) begin : g_sel
    assign hit_sel[g] = load_i && (ptr_q == OFS_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (open_i) begin
      ptr_q <= open_ofs_i;
    end else if (load_i) begin
      ptr_q <= ofs_step(ptr_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (open_i || clear_i) begin
      mask_q <= '0;
    end else begin
      mask_q <= mask_q | hit_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (hit_sel[i]) slot_q[i] <= load_data_i;
      end
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
  assign rd_hit_o  = mask_q[rd_idx_i];
  assign any_o     = |mask_q;
endmodule

// File: rtl/pgwr_walk.sv
module pgwr_walk #(
  parameter int unsigned OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  output logic             on_o,
  output logic [OFS_W-1:0] idx_o,
  output logic             last_o
);
  logic             on_q;
  logic [OFS_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      idx_q <= '0;
    end else if (go_i) begin
      on_q  <= 1'b1;
      idx_q <= '0;
    end else if (on_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == '1) on_q <= 1'b0;
    end
  end

  assign on_o   = on_q;
  assign idx_o  = idx_q;
  assign last_o = on_q && (idx_q == '1);
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int unsigned CYCLES = 40,
  localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (go_i) begin
      cnt_q <= CNT_W'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit
  import pgwr_pkg::*;
#(
  parameter int unsigned ADDR_W       = PG_ADDR_W,
  parameter int unsigned DATA_W       = PG_DATA_W,
  parameter int unsigned OFS_W        = PG_OFS_W,
  parameter int unsigned WRITE_CYCLES = PG_WR_TICKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_begin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_evt,
  input  logic              abort_evt,
  input  logic              wp_in,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              busy
);
  localparam int unsigned SLOTS  = 1 << OFS_W;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam int unsigned HOLD   = (WRITE_CYCLES < SLOTS) ? SLOTS : WRITE_CYCLES;

  function automatic logic [ADDR_W-1:0] join_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [OFS_W-1:0] of);
    return {pg, of};
  endfunction

  logic              loading_q;
  logic [PAGE_W-1:0] page_q;

  // named internal events
  logic          ev_abort, ev_open, ev_stop, ev_load;
  logic          buf_any, walk_on, walk_last, slot_hit;
  logic [OFS_W-1:0]  walk_idx;
  logic [DATA_W-1:0] slot_data;
  stop_verdict_e verdict;
  logic          commit_go, drop_buf;

  assign ev_abort = abort_evt && !busy;
  assign ev_open  = wr_begin && !busy && !abort_evt;
  assign ev_stop  = stop_evt && !busy && loading_q && !abort_evt && !wr_begin;
  assign ev_load  = byte_vld && !busy && loading_q && !abort_evt && !wr_begin && !stop_evt;

  always_comb begin
    verdict = EV_NONE;
    if (ev_stop) verdict = (buf_any && !wp_in) ? EV_GO : EV_DROP;
  end

  assign commit_go = (verdict == EV_GO);
  assign drop_buf  = ev_abort || (verdict == EV_DROP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading_q <= 1'b0;
      page_q    <= '0;
    end else if (ev_abort || ev_stop) begin
      loading_q <= 1'b0;
    end else if (ev_open) begin
      loading_q <= 1'b1;
      page_q    <= wr_addr[ADDR_W-1:OFS_W];
    end
  end

  pgwr_fill #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (ev_open),
    .open_ofs_i (wr_addr[OFS_W-1:0]),
    .load_i     (ev_load),
    .load_data_i(byte_data),
    .clear_i    (drop_buf || walk_last),
    .rd_idx_i   (walk_idx),
    .rd_data_o  (slot_data),
    .rd_hit_o   (slot_hit),
    .any_o      (buf_any)
  );

  pgwr_walk #(.OFS_W(OFS_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (commit_go),
    .on_o  (walk_on),
    .idx_o (walk_idx),
    .last_o(walk_last)
  );

  pgwr_timer #(.CYCLES(HOLD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (commit_go),
    .busy_o(busy)
  );

  assign ram_we    = walk_on && slot_hit;
  assign ram_addr  = join_addr(page_q, walk_idx);
  assign ram_wdata = slot_data;
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned HOLD   = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              wp_in,
  input logic              commit_go
);
  localparam int unsigned SLOTS = 1 << OFS_W;
  localparam int unsigned RW    = $clog2(HOLD + 2);

  logic [RW-1:0] run_cnt;
  logic [OFS_W:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      wr_cnt  <= '0;
    end else begin
      run_cnt <= busy ? run_cnt + 1'b1 : '0;
      wr_cnt  <= busy ? wr_cnt + (OFS_W+1)'(ram_we) : '0;
    end
  end

  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy);

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RW'(HOLD)));

  assert_we_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (run_cnt < RW'(SLOTS)));

  assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> !wp_in);

  assert_rise_after_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && busy && $past(busy)) |->
      (ram_addr[ADDR_W-1:OFS_W] == $past(ram_addr[ADDR_W-1:OFS_W])));

  assert_write_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= (OFS_W+1)'(SLOTS));
endmodule

bind pgwr_commit pgwr_commit_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .HOLD(HOLD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .wp_in    (wp_in),
  .commit_go(commit_go)
);

// File: tb/pgwr_commit_bench.sv
module pgwr_commit_bench;
  localparam int AW = 11, DW = 8, OW = 4, WC = 40, SLOTS = 16, MEMN = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_begin = 0, byte_vld = 0, stop_evt = 0, abort_evt = 0, wp_in = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] byte_data = '0;
  logic ram_we, busy;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  pgwr_commit #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .WRITE_CYCLES(WC)) u_pgwr_commit (
    .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt),
    .abort_evt(abort_evt), .wp_in(wp_in), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .busy(busy)
  );

  always #4 clk = ~clk;

  logic [7:0] ram [MEMN];
  logic [7:0] ref_mem [MEMN];
  int we_seen = 0;
  int n_chk = 0, n_bad = 0;

  always @(posedge clk) begin
    if (ram_we) begin
      ram[ram_addr] <= ram_wdata;
      we_seen++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int p, input int o, input int k);
    return 8'((p * 37 + o * 11 + k * 53 + 3) & 255);
  endfunction

  task automatic do_begin(input int a);
    wr_begin = 1; wr_addr = AW'(a); @(negedge clk); wr_begin = 0;
  endtask
  task automatic do_byte(input int d);
    byte_vld = 1; byte_data = DW'(d); @(negedge clk); byte_vld = 0;
  endtask
  task automatic do_stop();
    stop_evt = 1; @(negedge clk); stop_evt = 0;
  endtask
  task automatic do_abort();
    abort_evt = 1; @(negedge clk); abort_evt = 0;
  endtask

  task automatic measure(output int b);
    b = 0;
    while (busy && b < WC + 10) begin b++; @(negedge clk); end
  endtask

  task automatic idle_watch(output int hi);
    hi = 0;
    for (int i = 0; i < WC + 4; i++) begin if (busy) hi++; @(negedge clk); end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0, first = 0;
    for (int i = 0; i < MEMN; i++) begin
      if (ram[i] !== ref_mem[i]) begin
        if (bad == 0) first = i;
        bad++;
      end
    end
    check(bad == 0, tag, int'(ram[first]), int'(ref_mem[first]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 actual=timeout expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b, hi, we0, pg, base;
    for (int i = 0; i < MEMN; i++) begin ram[i] = 0; ref_mem[i] = 0; end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(ram_we == 1'b0, "R1 ram_we in reset", int'(ram_we), 0);
    rst_n = 1;
    @(negedge clk);
    // R10 first: a stop with nothing loaded, right after reset (also R1 empty buffer)
    we0 = we_seen;
    do_begin(12'h123); do_stop(); idle_watch(hi);
    check(hi == 0, "R10 R1 empty stop busy cycles", hi, 0);
    check(we_seen == we0, "R10 empty stop writes", we_seen - we0, 0);

    // sweep: every start offset, lengths 1..20 (R2 R3 R5 R8)
    for (int s = 0; s < SLOTS; s++) begin
      for (int len = 1; len <= 20; len++) begin
        pg = (s * 20 + len) % 128;
        base = pg * 16 + s;
        we0 = we_seen;
        do_begin(base);
        for (int k = 0; k < len; k++) begin
          do_byte(pat(pg, s, k));
          ref_mem[pg * 16 + ((s + k) % 16)] = pat(pg, s, k);
        end
        check(we_seen == we0, "R4 no write before stop", we_seen - we0, 0);
        do_stop();
        measure(b);
        check(b == WC, "R8 busy length", b, WC);
        check(we_seen - we0 == (len > 16 ? 16 : len), "R5 write count",
              we_seen - we0, (len > 16 ? 16 : len));
        cmp_mem("R2 R3 memory after page commit");
      end
    end

    // R4: long pause while collecting
    we0 = we_seen;
    do_begin(16 * 5 + 3); do_byte(8'hA1); do_byte(8'hA2);
    repeat (20) @(negedge clk);
    check(we_seen == we0 && busy == 0, "R4 idle while collecting", we_seen - we0, 0);
    do_stop(); measure(b);
    ref_mem[16 * 5 + 3] = 8'hA1; ref_mem[16 * 5 + 4] = 8'hA2;
    cmp_mem("R4 commit after pause");

    // R6: abort before stop
    we0 = we_seen;
    do_begin(16 * 9); do_byte(8'h55); do_byte(8'h66); do_abort(); do_stop();
    idle_watch(hi);
    check(hi == 0, "R6 abort busy cycles", hi, 0);
    check(we_seen == we0, "R6 abort writes", we_seen - we0, 0);
    cmp_mem("R6 memory after abort");

    // R6: reopen discards first set
    we0 = we_seen;
    do_begin(16 * 10 + 2); do_byte(8'h11); do_byte(8'h22);
    do_begin(16 * 11 + 7); do_byte(8'h33); do_stop(); measure(b);
    ref_mem[16 * 11 + 7] = 8'h33;
    check(we_seen - we0 == 1, "R6 reopen write count", we_seen - we0, 1);
    cmp_mem("R6 memory after reopen");

    // R7: write protect at stop, then a short sequence writes only its byte
    we0 = we_seen;
    do_begin(16 * 12); for (int k = 0; k < 8; k++) do_byte(8'hC0 + k);
    wp_in = 1; do_stop(); wp_in = 0; idle_watch(hi);
    check(hi == 0, "R7 protected busy cycles", hi, 0);
    check(we_seen == we0, "R7 protected writes", we_seen - we0, 0);
    do_begin(16 * 12 + 9); do_byte(8'hEE); do_stop(); measure(b);
    ref_mem[16 * 12 + 9] = 8'hEE;
    check(we_seen - we0 == 1, "R7 buffer dropped", we_seen - we0, 1);
    cmp_mem("R7 memory after protect");

    // R9: strobes during busy ignored
    we0 = we_seen;
    do_begin(16 * 13 + 1); do_byte(8'h77); do_stop();
    do_begin(16 * 14); do_byte(8'h88); do_stop(); do_abort();
    measure(b);
    check(b + 4 == WC, "R9 busy not extended", b + 4, WC);
    idle_watch(hi);
    check(hi == 0, "R9 no second cycle", hi, 0);
    ref_mem[16 * 13 + 1] = 8'h77;
    check(we_seen - we0 == 1, "R9 write count", we_seen - we0, 1);
    cmp_mem("R9 memory after busy strobes");

    // R11: abort and stop in one cycle -> abort wins
    we0 = we_seen;
    do_begin(16 * 15); do_byte(8'h99);
    abort_evt = 1; stop_evt = 1; @(negedge clk); abort_evt = 0; stop_evt = 0;
    idle_watch(hi);
    check(hi == 0 && we_seen == we0, "R11 abort over stop", hi, 0);
    // R11: stop with byte in one cycle -> stop wins, byte dropped
    do_begin(16 * 15 + 4); do_byte(8'h5A);
    stop_evt = 1; byte_vld = 1; byte_data = 8'hA5; @(negedge clk);
    stop_evt = 0; byte_vld = 0;
    measure(b);
    ref_mem[16 * 15 + 4] = 8'h5A;
    check(we_seen - we0 == 1, "R11 stop over byte", we_seen - we0, 1);
    cmp_mem("R11 memory after priority");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule